// File: doc/BRIEF.md
# Modem Status Change Tracker

This block watches the four active-low modem handshake inputs of a serial port (clear-to-send, data-set-ready, ring indicator, carrier detect). It resynchronises them into the local clock domain and presents them as one status byte. The upper nibble gives the present asserted state of each line. The lower nibble holds one change flag per line. A change flag is set by any transition of its line and stays set until software reads the status byte. Any set flag can raise an interrupt request.

The same block drives the two active-low handshake outputs (terminal-ready and request-to-send) from a control byte. That byte also carries two general-purpose output bits, a loopback select and a master modem enable. In loopback the external input pins are ignored, and the status lines are fed from the control bits instead. A driver can therefore exercise the change logic without a cable attached.

Top module: `modem_status_tracker`

## Requirements
- R1: Each input pin passes through a two-flop synchroniser. A level applied to a pin shows in the status byte after the third rising clock edge, and not after the second.
- R2: Status bits 4, 5, 6 and 7 hold the asserted state of CTS, DSR, RI and DCD, where 1 means the pin is low. All four read 0 while control bit 7 (modem enable) is 0.
- R3: Status bits 0, 1, 2 and 3 are set by any change in the asserted state of CTS, DSR, RI and DCD respectively, while modem enable is 1. They stay set while no read occurs.
- R4: A clock edge with the read strobe high clears all change flags. A change recorded on that same edge is kept set.
- R5: Output dtr_n is the inverse of control bit 0 and rts_n is the inverse of control bit 1, each registered one clock after the control byte.
- R6: With control bit 2 (OUT1) at 0 the RI state reads 0. With control bit 3 (OUT2) at 0 the DCD state reads 0, whatever the pins are.
- R7: With control bit 4 (loopback) at 1, the CTS state follows control bit 1, DSR follows bit 0, RI follows bit 2 and DCD follows bit 3, one edge after the control byte changes. The external pins then have no effect.
- R8: The interrupt request is registered. It is 1 on the edge after a cycle in which the updated change flags are non-zero, irq_en is 1 and modem enable is 1.
- R9: While modem enable is 0, line changes set no change flag. Turning the enable on does not create a flag by itself.
- R10: After synchronous reset the status byte and irq are 0, and dtr_n and rts_n are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_in | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_in | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_in | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_in | input | 1 | Carrier detect pin, active low, asynchronous |
| ctrl_byte | input | 8 | Control: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback, bit7 modem enable |
| status_rd | input | 1 | Read strobe for the status byte, one cycle per read |
| irq_en | input | 1 | Modem-status interrupt enable |
| status_byte | output | 8 | Bits 7:4 line states (DCD, RI, DSR, CTS), bits 3:0 change flags |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A read strobe and a freshly synchronised line change can meet on the same clock edge. On that edge the clear and the set of a change flag collide. The bench provokes this by driving a pin transition exactly two edges before the edge on which the read strobe is high, so that the third synchroniser-to-state edge coincides with the read. The result is judged by requiring that the flag of the new change remains set while the older flag of a different line is cleared. A random phase then mixes pin toggles, control changes and reads, so that further collisions occur. A cycle model checks each of these.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int LINES = 4;

  // control byte bit positions (decoded by the line selector)
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;
  localparam int CB_MEN  = 7;

  // line index inside every nibble
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  typedef struct packed {
    logic men;
    logic loopb;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.men   = b[CB_MEN];
    c.loopb = b[CB_LOOP];
    c.out2  = b[CB_OUT2];
    c.out1  = b[CB_OUT1];
    c.rts   = b[CB_RTS];
    c.dtr   = b[CB_DTR];
    return c;
  endfunction
endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mst_linesel.sv
module mst_linesel
  import mst_pkg::*;
(
  input  logic [LINES-1:0] pins_n,
  input  ctrl_t            ctrl,
  output logic [LINES-1:0] act
);
  always_comb begin
    if (ctrl.loopb) begin
      act         = '0;
      act[LN_CTS] = ctrl.rts;
      act[LN_DSR] = ctrl.dtr;
      act[LN_RI]  = ctrl.out1;
      act[LN_DCD] = ctrl.out2;
    end else begin
      act         = ~pins_n;
      act[LN_RI]  = ~pins_n[LN_RI]  & ctrl.out1;
      act[LN_DCD] = ~pins_n[LN_DCD] & ctrl.out2;
    end
  end
endmodule

// File: rtl/mst_delta.sv
module mst_delta #(
  parameter int L = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [L-1:0] act,
  input  logic         men,
  input  logic         rd,
  input  logic         irq_en,
  output logic [L-1:0] vis_q,
  output logic [L-1:0] delta_q,
  output logic         irq_q
);
  logic [L-1:0] state_q;
  logic [L-1:0] edge_w;
  logic [L-1:0] delta_d;

  assign edge_w  = men ? (act ^ state_q) : '0;
  assign delta_d = (delta_q & ~{L{rd}}) | edge_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      vis_q   <= '0;
      delta_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= act;
      vis_q   <= men ? act : '0;
      delta_q <= delta_d;
      irq_q   <= (|delta_d) & irq_en & men;
    end
  end

  // R3: flags are sticky between reads
  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !rd |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R4: after a read only changes seen on that edge survive
  assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
    rd |=> ((delta_q & ~$past(edge_w)) == '0));

  // R9: disabled block records no new change
  assert_no_record_R9: assert property (@(posedge clk) disable iff (rst)
    !men |=> (delta_q == ($past(delta_q) & ~{L{$past(rd)}})));

  // R8: a raised request always has a flag behind it
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (delta_q != '0));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import mst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_n_in,
  input  logic       dsr_n_in,
  input  logic       ri_n_in,
  input  logic       dcd_n_in,
  input  logic [7:0] ctrl_byte,
  input  logic       status_rd,
  input  logic       irq_en,
  output logic [7:0] status_byte,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       irq
);
  ctrl_t            ctrl;
  logic [LINES-1:0] pins_raw_n;
  logic [LINES-1:0] pins_sync_n;
  logic [LINES-1:0] act;
  logic [LINES-1:0] vis;
  logic [LINES-1:0] delta;

  assign ctrl = decode_ctrl(ctrl_byte);

  always_comb begin
    pins_raw_n         = '1;
    pins_raw_n[LN_CTS] = cts_n_in;
    pins_raw_n[LN_DSR] = dsr_n_in;
    pins_raw_n[LN_RI]  = ri_n_in;
    pins_raw_n[LN_DCD] = dcd_n_in;
  end

  mst_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw_n),
    .q   (pins_sync_n)
  );

  mst_linesel u_sel (
    .pins_n (pins_sync_n),
    .ctrl   (ctrl),
    .act    (act)
  );

  mst_delta #(.L(LINES)) u_delta (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .men     (ctrl.men),
    .rd      (status_rd),
    .irq_en  (irq_en),
    .vis_q   (vis),
    .delta_q (delta),
    .irq_q   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_n <= 1'b1;
      rts_n <= 1'b1;
    end else begin
      dtr_n <= ~ctrl.dtr;
      rts_n <= ~ctrl.rts;
    end
  end

  assign status_byte = {vis, delta};

  // R5: handshake outputs track the control byte one edge later
  assert_outputs_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dtr_n == !$past(ctrl_byte[CB_DTR]) && rts_n == !$past(ctrl_byte[CB_RTS])));

  // R7: in loopback the CTS state follows the RTS control bit
  assert_loop_cts_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_byte[CB_LOOP] && ctrl_byte[CB_MEN]) |=> (status_byte[4+LN_CTS] == $past(ctrl_byte[CB_RTS])));

  // R2: state nibble is blank while the block is disabled
  assert_blank_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_byte[CB_MEN] |=> (status_byte[7:4] == 4'h0));
endmodule

// File: tb/modem_status_tracker_tb.sv
`timescale 1ns/1ps
module modem_status_tracker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cts_n_in = 1'b1, dsr_n_in = 1'b1, ri_n_in = 1'b1, dcd_n_in = 1'b1;
  logic [7:0] ctrl_byte = 8'h00;
  logic       status_rd = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] status_byte;
  logic       dtr_n, rts_n, irq;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  modem_status_tracker u_dut (
    .clk(clk), .rst(rst),
    .cts_n_in(cts_n_in), .dsr_n_in(dsr_n_in), .ri_n_in(ri_n_in), .dcd_n_in(dcd_n_in),
    .ctrl_byte(ctrl_byte), .status_rd(status_rd), .irq_en(irq_en),
    .status_byte(status_byte), .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  bit [3:0] pin_pipe[$];
  bit [3:0] m_seen, m_src, m_prev, m_vis, m_delta, m_new;
  bit       m_irq, m_dtr_n, m_rts_n;

  always @(posedge clk) begin
    if (rst) begin
      pin_pipe = {};
      pin_pipe.push_back(4'hF);
      pin_pipe.push_back(4'hF);
      m_prev = 0; m_vis = 0; m_delta = 0; m_irq = 0;
      m_dtr_n = 1; m_rts_n = 1;
      started = 1;
    end else begin
      m_seen = pin_pipe.pop_front();
      pin_pipe.push_back({dcd_n_in, ri_n_in, dsr_n_in, cts_n_in});
      if (ctrl_byte[4]) begin
        m_src = {ctrl_byte[3], ctrl_byte[2], ctrl_byte[0], ctrl_byte[1]};
      end else begin
        m_src[0] = !m_seen[0];
        m_src[1] = !m_seen[1];
        m_src[2] = !m_seen[2] && ctrl_byte[2];
        m_src[3] = !m_seen[3] && ctrl_byte[3];
      end
      m_new = status_rd ? 4'h0 : m_delta;
      if (ctrl_byte[7]) m_new = m_new | (m_src ^ m_prev);
      m_irq   = (m_new != 0) && irq_en && ctrl_byte[7];
      m_vis   = ctrl_byte[7] ? m_src : 4'h0;
      m_prev  = m_src;
      m_delta = m_new;
      m_dtr_n = !ctrl_byte[0];
      m_rts_n = !ctrl_byte[1];
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R2 state nibble", {4'h0, status_byte[7:4]}, {4'h0, m_vis});
      check("R3 change flags", {4'h0, status_byte[3:0]}, {4'h0, m_delta});
      check("R8 irq",          {7'h0, irq},              {7'h0, m_irq});
      check("R5 outputs",      {6'h0, dtr_n, rts_n},     {6'h0, m_dtr_n, m_rts_n});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    // R10: reset state
    check("R10 status after reset", status_byte, 8'h00);
    check("R10 irq/dtr_n/rts_n after reset", {5'h0, irq, dtr_n, rts_n}, 8'h03);
    rst = 1'b0;
    ctrl_byte = 8'h8F;
    irq_en = 1'b1;
    tick(4);

    // R1: latency of a CTS assertion
    cts_n_in = 1'b0;
    tick(2);
    check("R1 not yet after two edges", {7'h0, status_byte[4]}, 8'h00);
    tick(1);
    check("R1 visible after third edge", status_byte[7:4] & 4'h1, 8'h01);
    check("R3 CTS flag set", {4'h0, status_byte[3:0]}, 8'h01);
    tick(1);
    check("R8 irq raised", {7'h0, irq}, 8'h01);
    tick(3);
    check("R3 flag still set without read", {4'h0, status_byte[3:0]}, 8'h01);

    // R4: read collides with a new DSR change
    dsr_n_in = 1'b0;
    tick(2);
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
    check("R4 new flag kept, old flag cleared", {4'h0, status_byte[3:0]}, 8'h02);
    check("R2 CTS and DSR asserted", {4'h0, status_byte[7:4]}, 8'h03);
    do_read();
    check("R4 plain read clears", {4'h0, status_byte[3:0]}, 8'h00);
    tick(1);
    check("R8 irq drops after clear", {7'h0, irq}, 8'h00);

    // R6: OUT1 low masks RI
    ctrl_byte = 8'h8B;
    ri_n_in = 1'b0;
    tick(5);
    check("R6 RI masked by OUT1", {7'h0, status_byte[6]}, 8'h00);
    check("R6 no RI flag while masked", {7'h0, status_byte[2]}, 8'h00);
    ctrl_byte = 8'h8F;
    tick(1);
    check("R6 RI appears when OUT1 set", {6'h0, status_byte[6], status_byte[2]}, 8'h03);
    ctrl_byte = 8'h87;
    dcd_n_in = 1'b0;
    tick(5);
    check("R6 DCD masked by OUT2", {7'h0, status_byte[7]}, 8'h00);
    do_read();

    // R7: loopback with only DTR set
    ctrl_byte = 8'h91;
    tick(1);
    check("R7 loopback DSR from DTR", {4'h0, status_byte[7:4]}, 8'h02);
    do_read();
    cts_n_in = 1'b1; dsr_n_in = 1'b1; ri_n_in = 1'b1; dcd_n_in = 1'b1;
    tick(5);
    check("R7 pins ignored in loopback", status_byte, 8'h20);
    ctrl_byte = 8'h9E;
    tick(1);
    check("R7 loopback follows RTS/OUT1/OUT2", {4'h0, status_byte[7:4]}, 8'h0D);

    // R9: disabled block records nothing
    ctrl_byte = 8'h0F;
    do_read();
    cts_n_in = 1'b0; dcd_n_in = 1'b0;
    tick(5);
    check("R9 no flags while disabled", status_byte, 8'h00);
    check("R9 irq low while disabled", {7'h0, irq}, 8'h00);
    ctrl_byte = 8'h8F;
    tick(1);
    check("R9 enable creates no flag", {4'h0, status_byte[3:0]}, 8'h00);
    check("R2 state after enable", {4'h0, status_byte[7:4]}, 8'h09);

    // R8: irq_en gates the request
    irq_en = 1'b0;
    cts_n_in = 1'b1;
    tick(5);
    check("R8 irq gated by irq_en", {7'h0, irq}, 8'h00);
    irq_en = 1'b1;
    tick(1);
    check("R8 irq after enable", {7'h0, irq}, 8'h01);

    // random mix, model compared on every cycle
    for (int k = 0; k < 600; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cts_n_in = r[0]; dsr_n_in = r[1]; ri_n_in = r[2]; dcd_n_in = r[3];
      if (($urandom % 8) == 0) ctrl_byte = {($urandom % 6) != 0, 2'b00, 1'(($urandom % 4) == 0), 4'($urandom)};
      status_rd = (($urandom % 4) == 0);
      irq_en = (($urandom % 8) != 0);
      tick(1 + ($urandom % 3));
    end
    status_rd = 1'b0;
    tick(2);
    finish_run();
  end
endmodule